// File: doc/BRIEF.md
# Infrared Receive Byte FIFO with Interrupt Status

This block sits between an infrared line sampler and a processor bus. The sampler delivers one run-length byte per strobe and a single-cycle pulse when it judges that a packet has finished. The block keeps those bytes in a small first-in first-out store. Software drains the store through a data register.

Three pending flags record when the store overflowed, when a packet ended, and when the stored level rose above a programmable threshold. The status register reports the flags together with the current byte count. Software clears the flags by writing ones to them. A single interrupt line is raised while any flag is pending and enabled.

The bus is a plain synchronous strobe interface. A write takes effect at the clock edge. Read data is combinational while the read strobe is high, and a read of the data register pops the byte at that edge.

Top module: `ir_rx_fifo`

## Requirements
- R1: After reset the store is empty, all pending flags and all enable fields are zero, and `irq` is low.
- R2: A read at offset 0x0 returns the oldest stored byte in bits 7:0 with all other bits zero, and removes that byte at the clock edge. A read of an empty store returns zero and changes nothing.
- R3: A sampler strobe while the store already holds DEPTH bytes drops the byte and sets the overflow flag (status bit 0) at that edge.
- R4: A read at offset 0x8 returns the byte count in bits starting at bit 8, with width clog2(DEPTH)+1. It also returns the flags in bits 0, 1 and 4, and zeros elsewhere.
- R5: The enable register at offset 0x4 holds the overflow enable in bit 0, the packet-end enable in bit 1, the data-available enable in bit 4, and the level threshold in bits starting at bit 8 (width clog2(DEPTH)+1). It reads back as written in those fields, with zeros elsewhere.
- R6: The data-available flag (status bit 4) is set at any edge where the registered count is greater than the threshold. While the count stays above the threshold, the flag stays set.
- R7: A pulse on `smp_pkt_end` sets the packet-end flag (status bit 1) at that edge, even when the store is empty.
- R8: A write at offset 0x8 clears each flag whose bit (0, 1 or 4) is written as one and leaves the others unchanged. A setting event at the same edge takes priority over the clear.
- R9: `irq` is high exactly when at least one pending flag has its enable bit set.
- R10: When a sampler byte is accepted and a data read pops at the same edge, the count is unchanged and byte order is kept. The count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sampler byte strobe |
| smp_byte | input | 8 | Run-length byte from the sampler |
| smp_pkt_end | input | 1 | Packet-end pulse from the sampler |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 16. At that depth the full and overflow conditions are reached within a few dozen cycles, so random traffic crosses the full boundary, the empty boundary and the threshold boundary many times. The default half-depth threshold of 7 is tested in a directed pass. Random writes to the enable register then sweep the threshold across its full range, including values at and beyond DEPTH, where the data-available flag can never be set.

// File: rtl/ir_rx_fifo.sv
module ir_rx_fifo #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [7:0]    smp_byte,
  input  logic          smp_pkt_end,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_ENA  = AW'(4);
  localparam logic [AW-1:0] A_STAT = AW'(8);
  localparam logic [CW-1:0] FULLV  = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt, thr;
  logic          en_ovf, en_pkt, en_da;
  logic          st_ovf, st_pkt, st_da;
  logic          full, empty, push, pop;
  logic [7:0]    clr;
  logic [31:0]   stat_w, ena_w, data_w;

  assign full  = cnt == FULLV;
  assign empty = cnt == '0;
  assign push  = smp_valid & ~full;
  assign pop   = bus_rd & (bus_addr == A_DATA) & ~empty;
  assign clr   = (bus_wr && bus_addr == A_STAT) ? bus_wdata[7:0] : 8'h00;

  always_ff @(posedge clk)
    if (push) mem[wp] <= smp_byte;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_ovf <= 1'b0;
      en_pkt <= 1'b0;
      en_da  <= 1'b0;
      thr    <= '0;
    end else if (bus_wr && bus_addr == A_ENA) begin
      en_ovf <= bus_wdata[0];
      en_pkt <= bus_wdata[1];
      en_da  <= bus_wdata[4];
      thr    <= bus_wdata[8 +: CW];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_ovf <= 1'b0;
      st_pkt <= 1'b0;
      st_da  <= 1'b0;
    end else begin
      st_ovf <= (st_ovf & ~clr[0]) | (smp_valid & full);
      st_pkt <= (st_pkt & ~clr[1]) | smp_pkt_end;
      st_da  <= (st_da  & ~clr[4]) | (cnt > thr);
    end

  assign data_w = empty ? 32'h0 : {24'h0, mem[rp]};
  assign ena_w  = (32'(thr) << 8) | {27'h0, en_da, 2'b00, en_pkt, en_ovf};
  assign stat_w = (32'(cnt) << 8) | {27'h0, st_da, 2'b00, st_pkt, st_ovf};

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd)
      case (bus_addr)
        A_DATA:  bus_rdata = data_w;
        A_ENA:   bus_rdata = ena_w;
        A_STAT:  bus_rdata = stat_w;
        default: bus_rdata = 32'h0;
      endcase
  end

  assign irq = (st_ovf & en_ovf) | (st_pkt & en_pkt) | (st_da & en_da);
endmodule

module ir_rx_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          smp_pkt_end,
  input logic          push,
  input logic          pop,
  input logic [CW-1:0] cnt,
  input logic          st_ovf,
  input logic          st_pkt
);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  // R3
  overflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && cnt == CW'(DEPTH)) |=> st_ovf);
  // R7
  pkt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_pkt_end |=> st_pkt);
  // R2
  pop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (cnt + 1'b1) == $past(cnt));
  // R10
  both_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && push) |=> $stable(cnt));
endmodule

bind ir_rx_fifo ir_rx_fifo_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_pkt_end(smp_pkt_end),
  .push(push), .pop(pop), .cnt(cnt), .st_ovf(st_ovf), .st_pkt(st_pkt)
);

// File: tb/ir_rx_fifo_test.sv
`timescale 1ns/1ps
module ir_rx_fifo_test;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH) + 1;

  logic clk = 0, rst_n = 0;
  logic smp_valid = 0, smp_pkt_end = 0, bus_rd = 0, bus_wr = 0;
  logic [7:0] smp_byte = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  ir_rx_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_byte(smp_byte),
    .smp_pkt_end(smp_pkt_end), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  logic [7:0] q[$];
  bit m_ovf, m_pkt, m_da, e_ovf, e_pkt, e_da;
  logic [CW-1:0] m_thr;

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return (q.size() > 0) ? {24'h0, q[0]} : 32'h0;
      4'h4: return (32'(m_thr) << 8) | {27'h0, e_da, 2'b00, e_pkt, e_ovf};
      4'h8: return (32'(q.size()) << 8) | {27'h0, m_da, 2'b00, m_pkt, m_ovf};
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit exp_irq();
    return (m_ovf & e_ovf) | (m_pkt & e_pkt) | (m_da & e_da);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input bit wv, input logic [7:0] wd, input bit pe, input bit rd,
                      input bit wr, input logic [3:0] ad, input logic [31:0] wdt,
                      input string tag);
    int n;
    bit full, pop;
    logic [7:0] c;
    @(negedge clk);
    smp_valid = wv; smp_byte = wd; smp_pkt_end = pe;
    bus_rd = rd; bus_wr = wr; bus_addr = ad; bus_wdata = wdt;
    #1;
    if (rd) chk(tag, bus_rdata, exp_read(ad));
    chk("R9", {31'h0, irq}, {31'h0, exp_irq()});
    @(posedge clk);
    n = q.size();
    full = (n == DEPTH);
    pop = rd && ad == 4'h0 && n > 0;
    c = (wr && ad == 4'h8) ? wdt[7:0] : 8'h00;
    m_ovf = (m_ovf & ~c[0]) | (wv & full);
    m_pkt = (m_pkt & ~c[1]) | pe;
    m_da  = (m_da & ~c[4]) | (n > int'(m_thr));
    if (pop) void'(q.pop_front());
    if (wv && !full) q.push_back(wd);
    if (wr && ad == 4'h4) begin
      e_ovf = wdt[0]; e_pkt = wdt[1]; e_da = wdt[4]; m_thr = wdt[8 +: CW];
    end
  endtask

  task automatic rd_reg(input logic [3:0] ad, input string tag);
    step(0, 0, 0, 1, 0, ad, 0, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int r;
    r = $urandom(32'd1234);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    rd_reg(4'h8, "R1");
    rd_reg(4'h4, "R1");
    rd_reg(4'h0, "R1");
    // R5 program enables, half-depth threshold
    step(0, 0, 0, 0, 1, 4'h4, 32'h13 | ((DEPTH/2 - 1) << 8), "R5");
    rd_reg(4'h4, "R5");
    // R6 threshold crossing
    for (int i = 0; i < DEPTH/2; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0, "R6");
    rd_reg(4'h8, "R6");
    rd_reg(4'h8, "R6");
    step(0, 0, 0, 0, 1, 4'h8, 32'h10, "R6");
    rd_reg(4'h8, "R6");
    // R3 overflow
    for (int i = DEPTH/2; i < DEPTH + 2; i++) step(1, 8'h10 + 8'(i), 0, 0, 0, 0, 0, "R3");
    rd_reg(4'h8, "R3");
    // R2 ordered pops
    rd_reg(4'h0, "R2");
    rd_reg(4'h0, "R2");
    // R10 write and pop together
    step(1, 8'hA5, 0, 1, 0, 4'h0, 0, "R10");
    rd_reg(4'h8, "R10");
    // R8 partial clear
    step(0, 0, 0, 0, 1, 4'h8, 32'h01, "R8");
    rd_reg(4'h8, "R8");
    // R2 drain, including empty reads
    for (int i = 0; i < DEPTH + 2; i++) rd_reg(4'h0, "R2");
    // R7 packet end on empty store
    step(0, 0, 1, 0, 0, 0, 0, "R7");
    rd_reg(4'h8, "R7");
    // R8 set wins over clear
    step(0, 0, 1, 0, 1, 4'h8, 32'h13, "R8");
    rd_reg(4'h8, "R8");
    step(0, 0, 0, 0, 1, 4'h8, 32'hFF, "R8");
    rd_reg(4'h8, "R8");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      bit wv, pe, rd, wr;
      logic [3:0] ad;
      logic [31:0] wd;
      int s;
      wv = ($urandom % 3) == 0;
      pe = ($urandom % 40) == 0;
      s = $urandom % 10;
      rd = s < 5;
      wr = (s == 5) || (s == 6 && ($urandom % 4) == 0);
      ad = (s < 2) ? 4'h8 : (s < 4) ? 4'h0 : (s == 4) ? 4'h4 : (s == 5) ? 4'h8 : 4'h4;
      wd = $urandom;
      step(wv, 8'($urandom), pe, rd, wr, ad, wd,
           ad == 4'h0 ? "R2" : ad == 4'h4 ? "R5" : "R4");
    end
    step(0, 0, 0, 1, 0, 4'h8, 0, "R4");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule